// File: doc/BRIEF.md
# Multistep 32-bit Load/Store Processor Core

This core executes a nine-instruction subset of a classic 32-bit RISC instruction set: word load, word store, add, subtract, and, or, set-on-less-than, branch-if-equal and jump. It does not finish an instruction in one long cycle. Each instruction is broken into short steps, and a control state machine sequences them. A single ALU serves every step: it computes the next PC in fetch, the speculative branch target in decode, and the address, arithmetic result or branch comparison in execute. Values that have to survive from one step to the next are kept in internal holding registers: the instruction register, two operand latches, an ALU result latch and a memory data latch.

The core has a single memory port that serves both instruction fetch and data access. The port consists of an address output, a write-data output, a write strobe and a read-data input. The read-data input is expected to return the addressed word in the same cycle. The core holds a 32-entry register file. A fetched word whose encoding is not supported stops the core in an idle state, and only reset releases it.

Top module: `multistep_cpu`

## Requirements
- R1: While reset is low, the PC is 0, `memAddr` is 0, `memWe` is 0 and `halted` is 0. After release, the first step fetches from address 0.
- R2: Every instruction begins with a fetch that loads the word at the PC and advances the PC by 4. During the following decode step, `memAddr` shows the advanced PC.
- R3: A word load (opcode bits [31:26] = 6'h23) writes the word at rs + sign-extended imm[15:0] into register rt. It takes 5 cycles.
- R4: A word store (opcode 6'h2B) drives register rt onto `memWData` at address rs + sign-extended imm. `memWe` is high for exactly one cycle, and the next cycle is a fetch. It takes 4 cycles.
- R5: Register-form instructions (opcode 6'h00) write rs op rt into register rd (bits [15:11]) with 32-bit wraparound. The funct field (bits [5:0]) selects the operation: 6'h20 add, 6'h22 subtract, 6'h24 and, 6'h25 or. They take 4 cycles.
- R6: funct 6'h2A compares rs and rt as signed numbers and writes 1 to rd when rs < rt, otherwise 0.
- R7: Branch-if-equal (opcode 6'h04) takes 3 cycles. When rs equals rt, it moves the PC to (address + 4) + sign-extended imm × 4. Otherwise execution continues with the next word.
- R8: Jump (opcode 6'h02) takes 3 cycles. It sets the PC to {PC[31:28], instr[25:0], 2'b00}.
- R9: Register 0 reads as zero, and writes to it have no effect.
- R10: An unsupported opcode, or a register-form funct outside the five listed, raises `halted` 2 cycles after that fetch begins. `halted` then stays high until reset, and no memory write occurs while it is high.
- R11: Instruction fetch and data access share one port. `memAddr` carries the PC during fetch and decode, and the computed address during data steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 32 | Byte address for fetch or data access |
| memWData | output | 32 | Store data |
| memWe | output | 1 | Memory write strobe |
| memRData | input | 32 | Word read at `memAddr`, valid in the same cycle |
| halted | output | 1 | Core stopped on an unsupported encoding |

## Verification
The bench sweeps operand pairs chosen to stress the ALU: overflow wraparound, opposite signs, equal values and bit patterns that partly overlap. A signed comparison implemented as unsigned would give the wrong set-on-less-than result for the mixed-sign pairs. Each run also counts total cycles. A step sequence that adds a step or skips one changes that total, even when every stored value is correct.

A counted loop runs for several trip counts. Each iteration includes a branch that is not taken and a backward jump, and the final iteration takes the branch. A wrong branch offset or comparison would end with the wrong sum or run into the watchdog. A store through a negative offset catches missing sign extension. A write aimed at register 0 that sticks would show up as a nonzero stored word. A bad funct field that did not halt the core would run on and write to memory.

// File: rtl/mscpu_pkg.sv
package mscpu_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int RIDX  = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;

  typedef enum logic [1:0] {AOP_ADD = 2'd0, AOP_SUB = 2'd1, AOP_FUNCT = 2'd2} aluOpT;
  typedef enum logic [1:0] {SB_REG = 2'd0, SB_FOUR = 2'd1, SB_IMM = 2'd2, SB_IMMX4 = 2'd3} srcBT;
  typedef enum logic [1:0] {PS_ALU = 2'd0, PS_LATCH = 2'd1, PS_JUMP = 2'd2} pcSrcT;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_RDMEM, ST_WRMEM, ST_LDWB,
    ST_EXEC, ST_RWB, ST_BRANCH, ST_JUMP, ST_HALT
  } stepT;

  typedef struct packed {
    logic  pcWrite;
    logic  pcWriteCond;
    pcSrcT pcSrc;
    logic  iorD;
    logic  memWrite;
    logic  irWrite;
    logic  regWrite;
    logic  regDst;
    logic  memToReg;
    logic  srcAReg;
    srcBT  srcB;
    aluOpT aluOp;
  } strobeT;
endpackage

// File: rtl/mscpu_aluctl.sv
module mscpu_aluctl
  import mscpu_pkg::*;
(
  input  aluOpT      aluOp,
  input  logic [5:0] funct,
  output logic [3:0] aluCode
);
  always_comb begin
    case (aluOp)
      AOP_ADD: aluCode = ALU_ADD;
      AOP_SUB: aluCode = ALU_SUB;
      default: begin
        case (funct)
          FN_ADD:  aluCode = ALU_ADD;
          FN_SUB:  aluCode = ALU_SUB;
          FN_AND:  aluCode = ALU_AND;
          FN_OR:   aluCode = ALU_OR;
          FN_SLT:  aluCode = ALU_SLT;
          default: aluCode = ALU_AND;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/mscpu_ctrl.sv
module mscpu_ctrl
  import mscpu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output strobeT     ctl,
  output logic       halted
);
  stepT state, stateNext;
  logic functOk;

  assign functOk = (funct == FN_ADD) || (funct == FN_SUB) || (funct == FN_AND) ||
                   (funct == FN_OR)  || (funct == FN_SLT);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_FETCH:  stateNext = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STORE: stateNext = ST_ADDR;
          OP_RTYPE:          stateNext = functOk ? ST_EXEC : ST_HALT;
          OP_BEQ:            stateNext = ST_BRANCH;
          OP_JUMP:           stateNext = ST_JUMP;
          default:           stateNext = ST_HALT;
        endcase
      end
      ST_ADDR:   stateNext = (opcode == OP_LOAD) ? ST_RDMEM : ST_WRMEM;
      ST_RDMEM:  stateNext = ST_LDWB;
      ST_EXEC:   stateNext = ST_RWB;
      ST_LDWB, ST_WRMEM, ST_RWB, ST_BRANCH, ST_JUMP: stateNext = ST_FETCH;
      default:   stateNext = ST_HALT;
    endcase
  end

  always_comb begin
    ctl = '0;
    ctl.aluOp = AOP_ADD;
    ctl.srcB  = SB_REG;
    ctl.pcSrc = PS_ALU;
    case (state)
      ST_FETCH: begin
        ctl.irWrite = 1'b1;
        ctl.pcWrite = 1'b1;
        ctl.srcB    = SB_FOUR;
      end
      ST_DECODE: ctl.srcB = SB_IMMX4;
      ST_ADDR: begin
        ctl.srcAReg = 1'b1;
        ctl.srcB    = SB_IMM;
      end
      ST_RDMEM: ctl.iorD = 1'b1;
      ST_WRMEM: begin
        ctl.iorD     = 1'b1;
        ctl.memWrite = 1'b1;
      end
      ST_LDWB: begin
        ctl.regWrite = 1'b1;
        ctl.memToReg = 1'b1;
      end
      ST_EXEC: begin
        ctl.srcAReg = 1'b1;
        ctl.aluOp   = AOP_FUNCT;
      end
      ST_RWB: begin
        ctl.regWrite = 1'b1;
        ctl.regDst   = 1'b1;
      end
      ST_BRANCH: begin
        ctl.srcAReg     = 1'b1;
        ctl.aluOp       = AOP_SUB;
        ctl.pcWriteCond = 1'b1;
        ctl.pcSrc       = PS_LATCH;
      end
      ST_JUMP: begin
        ctl.pcWrite = 1'b1;
        ctl.pcSrc   = PS_JUMP;
      end
      default: ;
    endcase
  end

  assign halted = (state == ST_HALT);
endmodule

// File: rtl/mscpu_dpath.sv
module mscpu_dpath
  import mscpu_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          ctl,
  input  logic [XLEN-1:0] memRData,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWData,
  output logic [5:0]      opcode,
  output logic [5:0]      funct
);
  logic [XLEN-1:0] pc, ir, regA, regB, aluOut, mdr;
  logic [XLEN-1:0] regs [NREGS];
  logic [RIDX-1:0] rsIdx, rtIdx, rdIdx, wIdx;
  logic [XLEN-1:0] rdA, rdB, simm, srcA, srcB, aluRes, wData, jumpTgt, pcNext;
  logic [3:0]      aluCode;
  logic            aluZero, pcLoad;

  assign opcode = ir[31:26];
  assign funct  = ir[5:0];
  assign rsIdx  = ir[25:21];
  assign rtIdx  = ir[20:16];
  assign rdIdx  = ir[15:11];
  assign simm   = {{(XLEN-16){ir[15]}}, ir[15:0]};

  assign rdA = (rsIdx == '0) ? '0 : regs[rsIdx];
  assign rdB = (rtIdx == '0) ? '0 : regs[rtIdx];

  assign srcA = ctl.srcAReg ? regA : pc;
  always_comb begin
    case (ctl.srcB)
      SB_REG:   srcB = regB;
      SB_FOUR:  srcB = XLEN'(4);
      SB_IMM:   srcB = simm;
      default:  srcB = {simm[XLEN-3:0], 2'b00};
    endcase
  end

  mscpu_aluctl u_aluctl (
    .aluOp  (ctl.aluOp),
    .funct  (funct),
    .aluCode(aluCode)
  );

  always_comb begin
    case (aluCode)
      ALU_AND: aluRes = srcA & srcB;
      ALU_OR:  aluRes = srcA | srcB;
      ALU_ADD: aluRes = srcA + srcB;
      ALU_SUB: aluRes = srcA - srcB;
      ALU_SLT: aluRes = ($signed(srcA) < $signed(srcB)) ? XLEN'(1) : '0;
      default: aluRes = '0;
    endcase
  end
  assign aluZero = (aluRes == '0);

  assign jumpTgt = {pc[XLEN-1:XLEN-4], ir[25:0], 2'b00};
  always_comb begin
    case (ctl.pcSrc)
      PS_ALU:   pcNext = aluRes;
      PS_LATCH: pcNext = aluOut;
      default:  pcNext = jumpTgt;
    endcase
  end
  assign pcLoad = ctl.pcWrite | (ctl.pcWriteCond & aluZero);

  assign wIdx  = ctl.regDst ? rdIdx : rtIdx;
  assign wData = ctl.memToReg ? mdr : aluOut;

  assign memAddr  = ctl.iorD ? aluOut : pc;
  assign memWData = regB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= RESET_PC;
      ir     <= '0;
      regA   <= '0;
      regB   <= '0;
      aluOut <= '0;
      mdr    <= '0;
    end else begin
      if (pcLoad)      pc <= pcNext;
      if (ctl.irWrite) ir <= memRData;
      regA   <= rdA;
      regB   <= rdB;
      aluOut <= aluRes;
      mdr    <= memRData;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && ctl.regWrite && (wIdx != '0)) regs[wIdx] <= wData;
  end
endmodule

// File: rtl/multistep_cpu.sv
module multistep_cpu
  import mscpu_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWData,
  output logic            memWe,
  input  logic [XLEN-1:0] memRData,
  output logic            halted
);
  strobeT     ctl;
  logic [5:0] opcode, funct;

  mscpu_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .opcode(opcode),
    .funct (funct),
    .ctl   (ctl),
    .halted(halted)
  );

  mscpu_dpath #(.RESET_PC(RESET_PC)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .memRData(memRData),
    .memAddr (memAddr),
    .memWData(memWData),
    .opcode  (opcode),
    .funct   (funct)
  );

  assign memWe = ctl.memWrite;
endmodule

// File: rtl/multistep_cpu_chk.sv
module multistep_cpu_chk
  import mscpu_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   memWe,
  input logic   halted,
  input strobeT ctl
);
  // R10: once stopped, the core stays stopped until reset
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R10: a stopped core never writes memory
  a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWe);

  // R4: the write strobe lasts one cycle
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R4: the cycle after a store is the next fetch
  a_r4_store_then_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> ctl.irWrite);

  // R2: a fetch is always followed by a decode step
  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rstN)
    ctl.irWrite |=> !ctl.irWrite);
endmodule

bind multistep_cpu multistep_cpu_chk i_chk (
  .clk   (clk),
  .rstN  (rstN),
  .memWe (memWe),
  .halted(halted),
  .ctl   (ctl)
);

// File: tb/test_multistep_cpu.sv
`timescale 1ns/1ps
module test_multistep_cpu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] memAddr, memWData, memRData;
  logic        memWe, halted;
  logic [31:0] mem [256];
  int nChecks = 0;
  int nErrors = 0;
  int nWrites = 0;

  always #2 clk = ~clk;

  multistep_cpu i_multistep_cpu (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWData(memWData),
    .memWe(memWe), .memRData(memRData), .halted(halted)
  );

  assign memRData = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (rstN && memWe) begin
      mem[memAddr[9:2]] <= memWData;
      nWrites = nWrites + 1;
    end
  end

  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  localparam logic [31:0] STOPW = 32'hFC00_0000;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_BEEF;
    for (int i = 0; i < 128; i++) mem[i] = STOPW;
  endtask

  task automatic startRun();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    nWrites = 0;
    rstN = 1'b1;
  endtask

  task automatic runProg(input int limit, output int cyc);
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (halted) break;
      if (cyc >= limit) begin
        nChecks++;
        nErrors++;
        $display("FAIL watchdog run actual=%0d expected<%0d", cyc, limit);
        break;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    nErrors++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] opA [7];
    logic [31:0] opB [7];
    int cyc;
    opA[0] = 32'd5;        opB[0] = 32'd3;
    opA[1] = 32'd3;        opB[1] = 32'd5;
    opA[2] = 32'hFFFF_FFFF; opB[2] = 32'd1;
    opA[3] = 32'h7FFF_FFFF; opB[3] = 32'd1;
    opA[4] = 32'h8000_0000; opB[4] = 32'h7FFF_FFFF;
    opA[5] = 32'h0000_1234; opB[5] = 32'h0000_1234;
    opA[6] = 32'hF0F0_F0F0; opB[6] = 32'h0FF0_0FF0;

    // R1: reset state and first fetch address
    clearMem();
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset memAddr", memAddr, 32'h0);
    chk("R1 reset memWe", {31'd0, memWe}, 32'd0);
    chk("R1 reset halted", {31'd0, halted}, 32'd0);
    mem[0] = encR(5'd0, 5'd0, 5'd1, 6'h20);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 pc+4 shown in decode", memAddr, 32'h4);

    // R3 R4 R5 R6 R9 R11: ALU sweep with loads and stores
    for (int p = 0; p < 7; p++) begin
      logic [31:0] a, b;
      a = opA[p]; b = opB[p];
      clearMem();
      mem[128] = a; mem[129] = b; mem[130] = 32'h320;
      mem[0]  = encI(6'h23, 5'd0, 5'd1, 16'h200);
      mem[1]  = encI(6'h23, 5'd0, 5'd2, 16'h204);
      mem[2]  = encI(6'h23, 5'd0, 5'd9, 16'h208);
      mem[3]  = encR(5'd1, 5'd2, 5'd3, 6'h20);
      mem[4]  = encR(5'd1, 5'd2, 5'd4, 6'h22);
      mem[5]  = encR(5'd1, 5'd2, 5'd5, 6'h24);
      mem[6]  = encR(5'd1, 5'd2, 5'd6, 6'h25);
      mem[7]  = encR(5'd1, 5'd2, 5'd7, 6'h2A);
      mem[8]  = encR(5'd2, 5'd1, 5'd8, 6'h2A);
      mem[9]  = encR(5'd1, 5'd2, 5'd0, 6'h20);
      mem[10] = encI(6'h2B, 5'd0, 5'd3, 16'h300);
      mem[11] = encI(6'h2B, 5'd0, 5'd4, 16'h304);
      mem[12] = encI(6'h2B, 5'd0, 5'd5, 16'h308);
      mem[13] = encI(6'h2B, 5'd0, 5'd6, 16'h30C);
      mem[14] = encI(6'h2B, 5'd0, 5'd7, 16'h310);
      mem[15] = encI(6'h2B, 5'd0, 5'd0, 16'h314);
      mem[16] = encI(6'h2B, 5'd9, 5'd8, 16'hFFFC);
      startRun();
      runProg(500, cyc);
      chk("R5 add", mem[192], a + b);
      chk("R5 sub", mem[193], a - b);
      chk("R5 and", mem[194], a & b);
      chk("R5 or", mem[195], a | b);
      chk("R6 slt a<b", mem[196], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
      chk("R9 r0 stays zero", mem[197], 32'd0);
      chk("R3 R11 negative offset store", mem[199], ($signed(b) < $signed(a)) ? 32'd1 : 32'd0);
      chk("R4 untouched word", mem[198], 32'hDEAD_BEEF);
      chk("R4 write count", nWrites, 32'd7);
      // 3 loads x5 + 7 register ops x4 + 7 stores x4 + stop 2
      chk("R3 R4 R5 cycle total", cyc, 32'd73);
    end

    // R7 R8: counted loop with branch and backward jump
    for (int n = 1; n <= 5; n++) begin
      clearMem();
      mem[128] = n; mem[129] = 32'd1;
      mem[0] = encI(6'h23, 5'd0, 5'd1, 16'h200);
      mem[1] = encI(6'h23, 5'd0, 5'd3, 16'h204);
      mem[2] = encR(5'd0, 5'd0, 5'd2, 6'h20);
      mem[3] = encR(5'd2, 5'd1, 5'd2, 6'h20);
      mem[4] = encR(5'd1, 5'd3, 5'd1, 6'h22);
      mem[5] = encI(6'h04, 5'd1, 5'd0, 16'h0001);
      mem[6] = {6'h02, 26'd3};
      mem[7] = encI(6'h2B, 5'd0, 5'd2, 16'h300);
      startRun();
      runProg(2000, cyc);
      chk("R7 R8 loop sum", mem[192], n * (n + 1) / 2);
      chk("R7 R8 loop cycles", cyc, 17 + 14 * n);
    end

    // R10: unsupported opcode
    clearMem();
    startRun();
    runProg(100, cyc);
    chk("R10 bad opcode cycles", cyc, 32'd2);

    // R10: unsupported funct, then stays stopped and silent
    clearMem();
    mem[0] = encR(5'd1, 5'd2, 5'd3, 6'h27);
    mem[1] = encI(6'h2B, 5'd0, 5'd0, 16'h300);
    startRun();
    runProg(100, cyc);
    chk("R10 bad funct cycles", cyc, 32'd2);
    repeat (10) @(negedge clk);
    chk("R10 halted sticky", {31'd0, halted}, 32'd1);
    chk("R10 no writes", nWrites, 32'd0);
    chk("R10 memory unchanged", mem[192], 32'hDEAD_BEEF);

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule